// File: doc/BRIEF.md
# SPI Frame Clock and Delay Timer

This block times one serial frame for an SPI controller. A one-cycle start request captures a 31-bit attribute word. The block then asserts the chip-select window and waits a programmed setup interval. It toggles SCK for the programmed number of bits, waits a programmed hold interval, and negates chip select. It then enforces a programmed idle gap before it accepts another frame. While SCK toggles it raises one-cycle shift and sample strobes and reports which bit position is being sampled. A data path next to it uses these to move bits in and out.

Each interval is the product of a small odd prescaler and a scaler. The SCK period uses prescalers of 2, 3, 5 or 7 and a tabulated scaler. The three delay intervals use prescalers of 1, 3, 5 or 7 and a power-of-two scaler. All counts are in system clock cycles. Queueing, FIFOs and the choice of attribute word belong to the surrounding controller.

Top module: `spi_frame_timer`

## Requirements
- R1: While reset is high and after its release, `cs_act`, `sck`, `shift_stb`, `sample_stb`, `frame_done` and `busy` are all 0.
- R2: While no frame is running, `sck` shows attribute bit 26 (clock polarity) one cycle after it is applied. When a frame is accepted, `sck` starts at that frame's polarity.
- R3: The SCK period is P = prescaler × scaler cycles. The prescaler comes from bits 17:16 (codes 0..3 give 2, 3, 5, 7). The scaler comes from bits 3:0 (codes 0..3 give 2, 4, 6, 8; a code c from 4 up gives 2^c). The active phase lasts ceil(P/2) when polarity is 0 and floor(P/2) when polarity is 1. The idle-level phase takes the rest.
- R4: A frame has N = bits 30:27 + 1 bits and produces exactly 2N SCK edges.
- R5: Chip select asserts in the cycle after the edge that accepts start. The first SCK edge follows exactly L cycles later. L = d(bits 23:22) × 2^(bits 15:12 + 1), where the delay prescaler d maps codes 0..3 to 1, 3, 5, 7.
- R6: Chip select negates exactly T cycles after the last SCK edge, with T = d(bits 21:20) × 2^(bits 11:8 + 1).
- R7: After negation, chip select stays low for at least G = d(bits 19:18) × 2^(bits 7:4 + 1) cycles. A start held during that gap is taken on its last cycle, so chip select stays low exactly G cycles. `busy` stays high through the gap and falls G cycles after negation.
- R8: With bit 25 (phase) at 0, leading edges carry `sample_stb` and trailing edges carry `shift_stb`. With it at 1 the roles swap. Each strobe is a one-cycle pulse in the cycle where `sck` first shows its edge, and there are N of each per frame.
- R9: In every cycle with `sample_stb`, `bit_idx` gives the position being sampled. It counts 0..N-1 when bit 24 (LSB first) is 1 and N-1..0 when it is 0.
- R10: `frame_done` is a single-cycle pulse in the first cycle chip select is low.
- R11: The attribute word is captured when start is accepted. Later changes to it, and start pulses during a frame, leave the running frame's timing unchanged and start no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one frame |
| attr | input | 31 | Attribute word (frame size, polarity, phase, order, prescalers, scalers) |
| sck | output | 1 | Serial clock |
| cs_act | output | 1 | Chip-select window, active high |
| shift_stb | output | 1 | Pulse on the SCK edge where data is driven |
| sample_stb | output | 1 | Pulse on the SCK edge where data is captured |
| bit_idx | output | 4 | Bit position for the current sample strobe |
| frame_done | output | 1 | Pulse when chip select negates |
| busy | output | 1 | High from accepted start to end of the idle gap |

## Verification
Two events can fall in the same cycle: a start request and the expiry of the idle gap. The bench provokes this by holding start high from before chip select negates. The gap is then correct only if chip select stays low for exactly G cycles, neither earlier nor later. A second overlap is a start pulse arriving in the middle of a running frame while the attribute word changes. That case is judged by the chip-select fall landing on the cycle computed from the first word, with no frame following it.

// File: rtl/spitm_pkg.sv
`timescale 1ns/1ps
package spitm_pkg;

  // attribute word, bit 30 down to bit 0
  typedef struct packed {
    logic [3:0] fsz;        // bits - 1
    logic       cpol;
    logic       cpha;
    logic       lsbf;
    logic [1:0] lead_pre;
    logic [1:0] trail_pre;
    logic [1:0] gap_pre;
    logic [1:0] baud_pre;
    logic [3:0] lead_scl;
    logic [3:0] trail_scl;
    logic [3:0] gap_scl;
    logic [3:0] baud_scl;
  } attr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL, ST_GAP
  } seq_st_t;

  // odd prescaler; the baud set starts at 2, the delay set at 1
  function automatic int unsigned pre_odd(input logic [1:0] code, input logic baud);
    case (code)
      2'd0:    return baud ? 2 : 1;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/spitm_div_calc.sv
`timescale 1ns/1ps
module spitm_div_calc #(
  parameter int CW      = 20,
  parameter bit IS_BAUD = 1'b0
) (
  input  logic [1:0]    pre,
  input  logic [3:0]    scl,
  output logic [CW-1:0] cycles
);
  import spitm_pkg::*;

  logic [CW-1:0] pre_v;
  logic [CW-1:0] scl_v;

  always_comb pre_v = CW'(pre_odd(pre, IS_BAUD));

  generate
    if (IS_BAUD) begin : g_baud
      // codes 0..3 step by two, from code 4 on powers of two
      always_comb scl_v = (scl < 4'd4) ? (CW'({scl, 1'b0}) + CW'(2)) : (CW'(1) << scl);
    end else begin : g_dly
      always_comb scl_v = CW'(2) << scl;
    end
  endgenerate

  always_comb cycles = pre_v * scl_v;

endmodule

// File: rtl/spitm_seq.sv
`timescale 1ns/1ps
module spitm_seq #(
  parameter int CW = 20,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cpol_live,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsbf,
  input  logic [FW-1:0] fsz,
  input  logic [CW-1:0] lead_len,
  input  logic [CW-1:0] trail_len,
  input  logic [CW-1:0] gap_len,
  input  logic [CW-1:0] pha_len,
  input  logic [CW-1:0] phb_len,
  output logic          take,
  output logic          sck,
  output logic          cs_act,
  output logic          shift_stb,
  output logic          sample_stb,
  output logic [FW-1:0] bit_idx,
  output logic          frame_done,
  output logic          busy
);
  import spitm_pkg::*;

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          ph;      // 0: active phase, 1: idle-level phase
  logic [FW-1:0] nbit;    // trailing edges produced so far
  logic          cnt_z;

  assign cnt_z = (cnt == '0);
  assign take  = start && ((st == ST_IDLE) || ((st == ST_GAP) && cnt_z));
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      ph         <= 1'b0;
      nbit       <= '0;
      bit_idx    <= '0;
      sck        <= 1'b0;
      cs_act     <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      frame_done <= 1'b0;
      if (take) begin
        st      <= ST_LEAD;
        cs_act  <= 1'b1;
        cnt     <= lead_len - CW'(1);
        nbit    <= '0;
        bit_idx <= lsbf ? '0 : fsz;
        sck     <= cpol;
      end else begin
        case (st)
          ST_IDLE: sck <= cpol_live;
          ST_LEAD: begin
            if (cnt_z) begin
              st  <= ST_XFER;
              ph  <= 1'b0;
              sck <= ~cpol;
              cnt <= pha_len - CW'(1);
              if (cpha) shift_stb  <= 1'b1;
              else      sample_stb <= 1'b1;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          ST_XFER: begin
            if (!cnt_z) begin
              cnt <= cnt - CW'(1);
            end else if (!ph) begin
              // trailing edge
              sck  <= cpol;
              nbit <= nbit + FW'(1);
              if (cpha) sample_stb <= 1'b1;
              else      shift_stb  <= 1'b1;
              if (nbit == fsz) begin
                st  <= ST_TRAIL;
                cnt <= trail_len - CW'(1);
              end else begin
                ph  <= 1'b1;
                cnt <= phb_len - CW'(1);
              end
            end else begin
              // leading edge of the next bit
              ph      <= 1'b0;
              sck     <= ~cpol;
              cnt     <= pha_len - CW'(1);
              bit_idx <= lsbf ? (bit_idx + FW'(1)) : (bit_idx - FW'(1));
              if (cpha) shift_stb  <= 1'b1;
              else      sample_stb <= 1'b1;
            end
          end
          ST_TRAIL: begin
            if (cnt_z) begin
              cs_act     <= 1'b0;
              frame_done <= 1'b1;
              st         <= ST_GAP;
              cnt        <= gap_len - CW'(1);
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          ST_GAP: begin
            if (cnt_z) st  <= ST_IDLE;
            else       cnt <= cnt - CW'(1);
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_frame_timer.sv
`timescale 1ns/1ps
module spi_frame_timer #(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [30:0] attr,
  output logic        sck,
  output logic        cs_act,
  output logic        shift_stb,
  output logic        sample_stb,
  output logic [3:0]  bit_idx,
  output logic        frame_done,
  output logic        busy
);
  import spitm_pkg::*;

  localparam int FW = 4;   // frame-size field width fixed by the word layout
  localparam int ND = 3;   // setup, hold, gap intervals

  attr_t a_in, cfg_q, cfg;
  logic  take;

  assign a_in = attr_t'(attr);
  // on the accepting cycle the live word drives all loads
  assign cfg  = take ? a_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (take) cfg_q <= a_in;
  end

  logic [1:0]       dpre [ND];
  logic [3:0]       dscl [ND];
  logic [CNT_W-1:0] dlen [ND];
  logic [CNT_W-1:0] period, pha_len, phb_len, half;

  always_comb begin
    dpre[0] = cfg.lead_pre;  dscl[0] = cfg.lead_scl;
    dpre[1] = cfg.trail_pre; dscl[1] = cfg.trail_scl;
    dpre[2] = cfg.gap_pre;   dscl[2] = cfg.gap_scl;
  end

  generate
    for (genvar g = 0; g < ND; g++) begin : g_dly
      spitm_div_calc #(.CW(CNT_W), .IS_BAUD(1'b0)) u_dly (
        .pre    (dpre[g]),
        .scl    (dscl[g]),
        .cycles (dlen[g])
      );
    end
  endgenerate

  spitm_div_calc #(.CW(CNT_W), .IS_BAUD(1'b1)) u_baud (
    .pre    (cfg.baud_pre),
    .scl    (cfg.baud_scl),
    .cycles (period)
  );

  // high phase takes the odd cycle
  assign half    = period >> 1;
  assign pha_len = cfg.cpol ? half : (period - half);
  assign phb_len = period - pha_len;

  spitm_seq #(.CW(CNT_W), .FW(FW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cpol_live  (a_in.cpol),
    .cpol       (cfg.cpol),
    .cpha       (cfg.cpha),
    .lsbf       (cfg.lsbf),
    .fsz        (cfg.fsz),
    .lead_len   (dlen[0]),
    .trail_len  (dlen[1]),
    .gap_len    (dlen[2]),
    .pha_len    (pha_len),
    .phb_len    (phb_len),
    .take       (take),
    .sck        (sck),
    .cs_act     (cs_act),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .bit_idx    (bit_idx),
    .frame_done (frame_done),
    .busy       (busy)
  );

endmodule

// File: rtl/spitm_chk.sv
`timescale 1ns/1ps
module spitm_chk (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic cs_act,
  input logic shift_stb,
  input logic sample_stb,
  input logic frame_done,
  input logic busy
);

  // R8: a strobe never marks both roles at once
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(shift_stb && sample_stb));

  // R8: every strobe sits on a cycle where sck has just moved
  p_strobe_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (shift_stb || sample_stb) |-> (sck != $past(sck)));

  // R8: inside a chip-select window no sck edge lacks a strobe
  p_edge_has_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act) && (sck != $past(sck))) |-> (shift_stb || sample_stb));

  // R10: done marks the first low cycle of chip select
  p_done_at_fall_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!cs_act && $past(cs_act)));

  // R10: done lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R7: the gap after negation still counts as busy
  p_busy_in_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_act) |-> busy);

  // R1: chip select is only asserted while busy
  p_cs_needs_busy_r1: assert property (@(posedge clk) disable iff (rst)
    cs_act |-> busy);

endmodule

bind spi_frame_timer spitm_chk u_spitm_chk (
  .clk        (clk),
  .rst        (rst),
  .sck        (sck),
  .cs_act     (cs_act),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb),
  .frame_done (frame_done),
  .busy       (busy)
);

// File: tb/test_spi_frame_timer.sv
`timescale 1ns/1ps
module test_spi_frame_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [30:0] attr = '0;
  logic        sck, cs_act, shift_stb, sample_stb, frame_done, busy;
  logic [3:0]  bit_idx;

  always #2.5 clk = ~clk;

  spi_frame_timer i_spi_frame_timer (
    .clk(clk), .rst(rst), .start(start), .attr(attr),
    .sck(sck), .cs_act(cs_act), .shift_stb(shift_stb), .sample_stb(sample_stb),
    .bit_idx(bit_idx), .frame_done(frame_done), .busy(busy)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [30:0] mk(input int fsz, cpol, cpha, lsb,
                                     lp, tp, gp, bp, ls, ts, gs, bs);
    return {4'(fsz), 1'(cpol), 1'(cpha), 1'(lsb), 2'(lp), 2'(tp), 2'(gp), 2'(bp),
            4'(ls), 4'(ts), 4'(gs), 4'(bs)};
  endfunction

  // fsz cpol cpha lsb | lead_pre trail_pre gap_pre baud_pre | lead_scl trail_scl gap_scl baud_scl
  // | expected setup L, period P, hold T, gap G
  localparam int VEC [6][16] = '{
    '{ 7, 0, 0, 0,  0, 0, 0, 0,  0, 0, 0, 0,   2,  4,  2,  2},
    '{ 3, 1, 1, 1,  1, 2, 0, 1,  0, 1, 1, 1,   6, 12, 20,  4},
    '{ 0, 0, 1, 0,  3, 0, 1, 2,  1, 2, 0, 0,  28, 10,  8,  6},
    '{15, 1, 0, 1,  0, 1, 0, 3,  2, 0, 0, 2,   8, 42,  6,  2},
    '{ 4, 0, 0, 1,  2, 3, 3, 0,  0, 1, 2, 4,  10, 32, 28, 56},
    '{ 1, 1, 1, 0,  1, 3, 2, 2,  3, 0, 1, 3,  48, 40, 14, 20}
  };

  function automatic logic [30:0] vec_attr(input int i);
    return mk(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5],
              VEC[i][6], VEC[i][7], VEC[i][8], VEC[i][9], VEC[i][10], VEC[i][11]);
  endfunction

  task automatic run_frame(input logic [30:0] a, input int n, cpol, cpha, lsb,
                           lead, per, trail, gap);
    int pa, pb, t, e_cnt, first_e, last_e, samp, shf, cs_fall, pa_m, pb_m;
    logic ps;
    pa = cpol ? per / 2 : per - per / 2;
    pb = per - pa;
    @(negedge clk);
    attr  = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    attr  = ~a;                       // R11: later word changes must not matter
    chk_eq("R5 cs asserted after accept", int'(cs_act), 1);
    chk_eq("R2 sck starts at frame polarity", int'(sck), cpol);
    ps = sck; t = 0; e_cnt = 0; first_e = -1; last_e = 0;
    samp = 0; shf = 0; cs_fall = -1; pa_m = -1; pb_m = -1;
    while (cs_fall < 0 && t < 100000) begin
      if (sck !== ps) begin
        e_cnt++;
        if (e_cnt == 1) first_e = t;
        if (e_cnt == 2) pa_m = t - last_e;
        if (e_cnt == 3) pb_m = t - last_e;
        // encoding {sample_stb, shift_stb}: 2 = sample, 1 = shift
        if (sck != 1'(cpol))
          chk_eq("R8 strobe on leading edge", int'({sample_stb, shift_stb}), cpha ? 1 : 2);
        else
          chk_eq("R8 strobe on trailing edge", int'({sample_stb, shift_stb}), cpha ? 2 : 1);
        last_e = t;
      end
      if (sample_stb) begin
        chk_eq("R9 bit index at sample", int'(bit_idx), lsb ? samp : n - 1 - samp);
        samp++;
      end
      if (shift_stb) shf++;
      if (!cs_act) cs_fall = t;
      else begin
        ps = sck;
        @(negedge clk);
        t++;
      end
    end
    chk_eq("R5 setup delay to first edge", first_e, lead);
    chk_eq("R4 edge count", e_cnt, 2 * n);
    chk_eq("R3 active phase length", pa_m, pa);
    if (n > 1) chk_eq("R3 idle-level phase length", pb_m, pb);
    chk_eq("R8 sample strobe count", samp, n);
    chk_eq("R8 shift strobe count", shf, n);
    chk_eq("R6 hold delay to negation", cs_fall - last_e, trail);
    chk_eq("R10 done with negation", int'(frame_done), 1);
    @(negedge clk);
    chk_eq("R10 done single cycle", int'(frame_done), 0);
    repeat (gap - 2) @(negedge clk);
    chk_eq("R7 busy through gap", int'(busy), 1);
    @(negedge clk);
    chk_eq("R7 busy falls after gap", int'(busy), 0);
    chk_eq("R11 no frame without start", int'(cs_act), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    wrap_up();
  end

  initial begin
    int t;
    // R1: reset state, during and after reset
    repeat (4) @(negedge clk);
    chk_eq("R1 cs in reset", int'(cs_act), 0);
    chk_eq("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 cs after reset", int'(cs_act), 0);
    chk_eq("R1 sck after reset", int'(sck), 0);
    chk_eq("R1 strobes after reset", int'({shift_stb, sample_stb}), 0);
    chk_eq("R1 done after reset", int'(frame_done), 0);
    chk_eq("R1 busy after reset", int'(busy), 0);

    // R2: idle clock level follows polarity bit
    attr = mk(7, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk_eq("R2 idle sck high", int'(sck), 1);
    attr = mk(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk_eq("R2 idle sck low", int'(sck), 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 6; i++)
      run_frame(vec_attr(i), VEC[i][0] + 1, VEC[i][1], VEC[i][2], VEC[i][3],
                VEC[i][12], VEC[i][13], VEC[i][14], VEC[i][15]);

    // R11: start and a new word mid-frame; negation at 2 + 7*4 + 2 + 2 = 34
    @(negedge clk);
    attr  = vec_attr(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    repeat (5) begin @(negedge clk); t++; end
    attr  = vec_attr(5);
    start = 1'b1;
    @(negedge clk);
    t++;
    start = 1'b0;
    while (cs_act && t < 1000) begin @(negedge clk); t++; end
    chk_eq("R11 frame kept captured timing", t, 34);
    repeat (8) @(negedge clk);
    chk_eq("R11 mid-frame start ignored", int'(cs_act), 0);
    chk_eq("R11 idle after ignored start", int'(busy), 0);

    // R7: start held across the gap is taken on its last cycle
    @(negedge clk);
    attr  = vec_attr(4);
    start = 1'b1;
    @(negedge clk);
    t = 0;
    while (cs_act && t < 5000) begin @(negedge clk); t++; end
    t = 0;
    while (!cs_act && t < 5000) begin @(negedge clk); t++; end
    chk_eq("R7 held start gap length", t, 56);
    start = 1'b0;
    t = 0;
    while (!frame_done && t < 5000) begin @(negedge clk); t++; end
    repeat (60) @(negedge clk);
    chk_eq("R7 idle after second frame", int'(busy), 0);

    wrap_up();
  end

endmodule